// File: doc/BRIEF.md
# Multi-Mode Self-Test Pattern Source

This block feeds an n-bit stimulus word to a circuit under test during built-in self-test. A pulse on `start` captures a seed, a scheme selector, a per-bit weight vector and a pattern count. The block then emits exactly that many patterns, one per clock, with `pattern_valid` high. After the last pattern it raises `done` for one cycle. Checking the responses and sequencing the wider test are the job of other blocks.

There are four schemes. Plain binary counting and a complete feedback shift register both reach every one of the 2^n words. The complete register is a maximal-length register with a zero-detect term added, so the all-zero word is also visited. A plain pseudorandom register gives a repeatable sequence without the zero word. A weighted scheme post-processes that same register so that each output bit can be biased toward zeros or toward ones.

Top module: `bist_tpg_gen`

## Requirements
- R1: After reset, and until the first accepted start, `pattern_valid` and `done` are both low.
- R2: A start pulse seen while no run is active is accepted. The run then presents exactly `pat_count` patterns, one per cycle, with `pattern_valid` high, starting in the cycle after the start edge. A start pulse during an active run is ignored.
- R3: `done` is high for exactly one cycle, namely the cycle right after the last valid pattern, and `pattern_valid` is low in that cycle. With `pat_count` equal to zero, `done` pulses in the cycle after the start edge and no valid pattern appears.
- R4: With mode code 0 (counting), the first pattern equals the seed, and pattern k equals seed + k modulo 2^n.
- R5: With mode code 1 (complete register), any 2^n consecutive patterns are all distinct and include the all-zero word. Pattern number 2^n equals the first pattern.
- R6: With mode code 2 (plain pseudorandom), the first pattern equals a nonzero seed. The sequence never contains zero and repeats with period 2^n - 1. The same seed always yields the same sequence.
- R7: With mode codes 2 and 3, an all-zero seed is replaced by the value 1, so the first register state is 1.
- R8: With mode code 3 (weighted), let s be the register state, which follows the same sequence as mode 2 with the same seed. Output bit i is set by weight field `weight_sel[2i+1:2i]`, with j = (i+1) mod n. Code 0 gives s[i] (probability 1/2). Code 1 gives s[i] AND s[j] (probability 1/4). Code 2 gives s[i] OR s[j] (probability 3/4). Code 3 gives NOT s[i].
- R9: The mode, seed, weight and count inputs are captured at the accepted start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while one is active) |
| mode | input | 2 | Scheme: 0 count, 1 complete register, 2 pseudorandom, 3 weighted |
| seed | input | WIDTH | Initial state |
| weight_sel | input | 2*WIDTH | Two-bit weight code per output bit |
| pat_count | input | CNT_W | Number of patterns in the run |
| pattern | output | WIDTH | Stimulus word |
| pattern_valid | output | 1 | Pattern is part of the run |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions rely on two things: `WIDTH` lies between 4 and 16, and inputs change only between clock edges. They do not constrain `start`. A run may be restarted or poked at any cycle, and the run-control properties still hold because a load and a register advance can never fall in the same cycle. The bench changes inputs on falling edges only. It also deliberately pulses `start` and alters every configuration input in the middle of a run, which exercises the capture-at-start rule.

// File: rtl/bist_tpg_pkg.sv
`timescale 1ns/1ps
package bist_tpg_pkg;

    localparam int unsigned TPG_MIN_W = 4;
    localparam int unsigned TPG_MAX_W = 16;

    typedef enum logic [1:0] {
        TPG_COUNT  = 2'd0,
        TPG_FULL   = 2'd1,
        TPG_PRAND  = 2'd2,
        TPG_WEIGHT = 2'd3
    } tpg_mode_e;

    typedef enum logic [1:0] {
        WGT_HALF    = 2'd0,
        WGT_QUARTER = 2'd1,
        WGT_THREEQ  = 2'd2,
        WGT_INVERT  = 2'd3
    } wgt_code_e;

    typedef struct packed {
        logic load;
        logic advance;
    } tpg_step_t;

    // Feedback mask (bit k set means stage k is tapped) of a maximal-length
    // shift register for each supported width; the top stage is always tapped.
    function automatic logic [TPG_MAX_W-1:0] tpg_tap_mask(input int unsigned w);
        case (w)
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            11:      return 16'h0500;
            12:      return 16'h0829;
            13:      return 16'h100D;
            14:      return 16'h2015;
            15:      return 16'h6000;
            default: return 16'hD008;
        endcase
    endfunction

    function automatic logic tpg_is_random(input tpg_mode_e m);
        return (m == TPG_PRAND) || (m == TPG_WEIGHT);
    endfunction

endpackage

// File: rtl/tpg_run_ctrl.sv
`timescale 1ns/1ps
module tpg_run_ctrl
    import bist_tpg_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pat_count,
    output tpg_step_t        step,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] remaining;

    assign step.load    = start & ~busy;
    assign step.advance = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            remaining <= '0;
        end else begin
            done <= 1'b0;
            if (step.load) begin
                if (pat_count == '0) begin
                    done <= 1'b1;
                end else begin
                    busy      <= 1'b1;
                    remaining <= pat_count;
                end
            end else if (busy) begin
                remaining <= remaining - CNT_ONE;
                if (remaining == CNT_ONE) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_busy_has_work_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (remaining != '0));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !(step.load && pat_count == '0)) |=> !done);

    assert_done_no_valid_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_end_gives_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

// File: rtl/tpg_state_core.sv
`timescale 1ns/1ps
module tpg_state_core
    import bist_tpg_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tpg_step_t        step,
    input  tpg_mode_e        mode_in,
    input  logic [WIDTH-1:0] seed,
    output tpg_mode_e        cur_mode,
    output logic [WIDTH-1:0] state
);
    localparam logic [TPG_MAX_W-1:0] MASK_FULL = tpg_tap_mask(WIDTH);
    localparam logic [WIDTH-1:0]     TAPS      = MASK_FULL[WIDTH-1:0];
    localparam logic [WIDTH-1:0]     SAFE_SEED = WIDTH'(1);
    localparam logic [WIDTH-1:0]     ONE       = WIDTH'(1);

    logic             fb_lin;
    logic             low_zero;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] load_val;

    assign fb_lin   = ^(state & TAPS);
    assign low_zero = (state[WIDTH-2:0] == '0);

    always_comb begin
        case (cur_mode)
            TPG_COUNT: nxt = state + ONE;
            TPG_FULL:  nxt = {state[WIDTH-2:0], fb_lin ^ low_zero};
            default:   nxt = {state[WIDTH-2:0], fb_lin};
        endcase
    end

    assign load_val = (tpg_is_random(mode_in) && seed == '0) ? SAFE_SEED : seed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= '0;
            cur_mode <= TPG_COUNT;
        end else if (step.load) begin
            state    <= load_val;
            cur_mode <= mode_in;
        end else if (step.advance) begin
            state    <= nxt;
        end
    end

    assert_no_lockup_R6: assert property (@(posedge clk) disable iff (rst)
        tpg_is_random(cur_mode) |-> (state != '0));

    assert_zero_seed_swap_R7: assert property (@(posedge clk) disable iff (rst)
        (step.load && tpg_is_random(mode_in) && seed == '0) |=> (state == ONE));

    assert_full_leaves_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (step.advance && cur_mode == TPG_FULL && state == '0) |=> (state == ONE));

    assert_steps_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(step.load && step.advance));

endmodule

// File: rtl/tpg_weight_shaper.sv
`timescale 1ns/1ps
module tpg_weight_shaper
    import bist_tpg_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0]   state,
    input  logic [2*WIDTH-1:0] weights,
    input  logic               enable,
    output logic [WIDTH-1:0]   pattern
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int unsigned J = (i + 1) % WIDTH;
        wgt_code_e code;
        logic      shaped;

        assign code = wgt_code_e'(weights[2*i +: 2]);

        always_comb begin
            case (code)
                WGT_QUARTER: shaped = state[i] & state[J];
                WGT_THREEQ:  shaped = state[i] | state[J];
                WGT_INVERT:  shaped = ~state[i];
                default:     shaped = state[i];
            endcase
        end

        assign pattern[i] = enable ? shaped : state[i];
    end

endmodule

// File: rtl/bist_tpg_gen.sv
`timescale 1ns/1ps
module bist_tpg_gen
    import bist_tpg_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [WIDTH-1:0]   seed,
    input  logic [2*WIDTH-1:0] weight_sel,
    input  logic [CNT_W-1:0]   pat_count,
    output logic [WIDTH-1:0]   pattern,
    output logic               pattern_valid,
    output logic               done
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    tpg_step_t          step;
    logic               busy;
    tpg_mode_e          cur_mode;
    logic [WIDTH-1:0]   state;
    logic [2*WIDTH-1:0] wgt_q;

    tpg_run_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pat_count (pat_count),
        .step      (step),
        .busy      (busy),
        .done      (done)
    );

    tpg_state_core #(.WIDTH(WIDTH)) core_i (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .mode_in  (tpg_mode_e'(mode)),
        .seed     (seed),
        .cur_mode (cur_mode),
        .state    (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wgt_q <= '0;
        end else if (step.load) begin
            wgt_q <= weight_sel;
        end
    end

    tpg_weight_shaper #(.WIDTH(WIDTH)) shaper_i (
        .state   (state),
        .weights (wgt_q),
        .enable  (cur_mode == TPG_WEIGHT),
        .pattern (pattern)
    );

    assign pattern_valid = busy;

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (pattern_valid && $past(pattern_valid) && cur_mode == TPG_COUNT)
            |-> (pattern == $past(pattern) + ONE));

    for (genvar i = 0; i < WIDTH; i++) begin : g_wchk
        assert_wgt_quarter_R8: assert property (@(posedge clk) disable iff (rst)
            (pattern_valid && cur_mode == TPG_WEIGHT &&
             wgt_q[2*i +: 2] == WGT_QUARTER && pattern[i]) |-> state[i]);

        assert_wgt_threeq_R8: assert property (@(posedge clk) disable iff (rst)
            (pattern_valid && cur_mode == TPG_WEIGHT &&
             wgt_q[2*i +: 2] == WGT_THREEQ && state[i]) |-> pattern[i]);

        assert_wgt_invert_R8: assert property (@(posedge clk) disable iff (rst)
            (pattern_valid && cur_mode == TPG_WEIGHT &&
             wgt_q[2*i +: 2] == WGT_INVERT) |-> (pattern[i] != state[i]));
    end

endmodule

// File: tb/bist_tpg_gen_tb_top.sv
`timescale 1ns/1ps
module bist_tpg_gen_tb_top;
    localparam int W  = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [W-1:0]  seed_i = '0;
    logic [2*W-1:0] wsel_i = '0;
    logic [CW-1:0] cnt_i = '0;
    logic [W-1:0]  pattern_o;
    logic          valid_o;
    logic          done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [W-1:0] cap [0:599];
    logic [W-1:0] ref_seq [0:299];
    int  cap_n;
    int  done_cnt;
    bit  done_pos_ok;

    always #10 clk = ~clk;

    bist_tpg_gen #(.WIDTH(W), .CNT_W(CW)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .start         (start_i),
        .mode          (mode_i),
        .seed          (seed_i),
        .weight_sel    (wsel_i),
        .pat_count     (cnt_i),
        .pattern       (pattern_o),
        .pattern_valid (valid_o),
        .done          (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_tpg(input logic [1:0] m, input logic [W-1:0] sd,
                           input logic [2*W-1:0] ws, input int n, input int poke);
        bit prev_v;
        mode_i = m; seed_i = sd; wsel_i = ws; cnt_i = CW'(n); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cap_n = 0; done_cnt = 0; done_pos_ok = 1; prev_v = 0;
        for (int k = 0; k < n + 4; k++) begin
            if (valid_o) begin
                if (cap_n < 600) cap[cap_n] = pattern_o;
                cap_n++;
                if (done_o) done_pos_ok = 0;
            end
            if (done_o) begin
                done_cnt++;
                if (!prev_v && n != 0) done_pos_ok = 0;
            end
            prev_v = valid_o;
            if (k == poke) begin
                start_i = 1'b1; mode_i = ~m; seed_i = 8'h80; wsel_i = ~ws; cnt_i = 16'd2;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic check_run_shape(input int n, input string tag);
        chk(cap_n == n, {tag, " R2 pattern count"}, cap_n, n);
        chk(done_cnt == 1 && done_pos_ok, {tag, " R3 done pulse"}, done_cnt, 1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!valid_o && !done_o, "R1 outputs in reset", {valid_o, done_o}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!valid_o && !done_o, "R1 idle after reset", {valid_o, done_o}, 0);
    endtask

    task automatic t_count;
        int bad = -1;
        run_tpg(2'd0, 8'hFA, '0, 10, -1);
        check_run_shape(10, "count");
        for (int k = 0; k < 10 && k < cap_n; k++)
            if (bad < 0 && cap[k] != W'(8'hFA + k)) bad = k;
        chk(bad < 0, "R4 counting sequence with wrap", bad, -1);
    endtask

    task automatic t_full;
        bit seen [0:255];
        int distinct = 0;
        run_tpg(2'd1, 8'h5A, '0, 257, -1);
        check_run_shape(257, "full");
        for (int k = 0; k < 256; k++) seen[k] = 0;
        for (int k = 0; k < 256; k++) begin
            if (!seen[cap[k]]) distinct++;
            seen[cap[k]] = 1;
        end
        chk(distinct == 256, "R5 all words distinct", distinct, 256);
        chk(seen[0], "R5 zero word visited", seen[0], 1);
        chk(cap[256] == cap[0] && cap[0] == 8'h5A, "R5 wraps to first", cap[256], cap[0]);
    endtask

    task automatic t_prand;
        bit seen [0:255];
        int distinct = 0;
        int zeros = 0;
        int bad = -1;
        run_tpg(2'd2, 8'h3C, '0, 256, -1);
        check_run_shape(256, "prand");
        for (int k = 0; k < 256; k++) seen[k] = 0;
        for (int k = 0; k < 255; k++) begin
            if (cap[k] == 0) zeros++;
            if (!seen[cap[k]]) distinct++;
            seen[cap[k]] = 1;
        end
        for (int k = 0; k < 256; k++) ref_seq[k] = cap[k];
        chk(cap[0] == 8'h3C, "R6 first equals seed", cap[0], 8'h3C);
        chk(zeros == 0 && distinct == 255, "R6 period 255 without zero", distinct, 255);
        chk(cap[255] == cap[0], "R6 repeats after 255", cap[255], cap[0]);
        run_tpg(2'd2, 8'h3C, '0, 40, -1);
        for (int k = 0; k < 40; k++) if (bad < 0 && cap[k] != ref_seq[k]) bad = k;
        chk(bad < 0, "R6 same seed same sequence", bad, -1);
    endtask

    task automatic t_zero_seed;
        run_tpg(2'd2, 8'h00, '0, 3, -1);
        chk(cap[0] == 8'h01, "R7 zero seed pseudorandom", cap[0], 1);
        run_tpg(2'd3, 8'h00, '0, 3, -1);
        chk(cap[0] == 8'h01, "R7 zero seed weighted", cap[0], 1);
        run_tpg(2'd0, 8'h00, '0, 2, -1);
        chk(cap[0] == 8'h00, "R7 zero seed kept in counting", cap[0], 0);
    endtask

    function automatic logic [W-1:0] wexp(input logic [W-1:0] s, input logic [2*W-1:0] ws);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            case (ws[2*i +: 2])
                2'd0: r[i] = s[i];
                2'd1: r[i] = s[i] & s[(i + 1) % W];
                2'd2: r[i] = s[i] | s[(i + 1) % W];
                default: r[i] = ~s[i];
            endcase
        end
        return r;
    endfunction

    task automatic t_weight;
        int bad = -1;
        logic [W-1:0] e = '0;
        run_tpg(2'd3, 8'h3C, 16'h39E4, 40, -1);
        check_run_shape(40, "weight");
        for (int k = 0; k < 40; k++) begin
            if (bad < 0 && cap[k] != wexp(ref_seq[k], 16'h39E4)) begin
                bad = k; e = wexp(ref_seq[k], 16'h39E4);
            end
        end
        chk(bad < 0, "R8 weighted bits", bad < 0 ? 0 : int'(cap[bad]), int'(e));
    endtask

    task automatic t_zero_count;
        run_tpg(2'd0, 8'h10, '0, 0, -1);
        chk(cap_n == 0, "R3 zero count gives no valid", cap_n, 0);
        chk(done_cnt == 1, "R3 zero count done pulse", done_cnt, 1);
    endtask

    task automatic t_ignore;
        int bad = -1;
        run_tpg(2'd0, 8'h00, 16'h0000, 12, 3);
        chk(cap_n == 12, "R2 restart ignored while busy", cap_n, 12);
        for (int k = 0; k < 12; k++) if (bad < 0 && cap[k] != W'(k)) bad = k;
        chk(bad < 0, "R9 inputs changed mid run ignored", bad, -1);
        chk(done_cnt == 1, "R3 single done after poked run", done_cnt, 1);
    endtask

    initial begin
        t_reset();
        t_count();
        t_full();
        t_prand();
        t_zero_seed();
        t_weight();
        t_zero_count();
        t_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule